// File: doc/BRIEF.md
# In-Band Command/Data Stream Parser

This block sits behind a byte receiver and splits a single serial byte stream into payload bytes and control commands. No side-band pin marks which is which. A mode flag says whether the stream is carrying commands or data. One reserved escape value (E3h) leaves data mode. The same value, sent twice in a row, carries a literal E3h as payload.

In data mode, bytes pass through to the downstream slot converter. In command mode, each byte is decoded into one of five request kinds: configuration write, single-bit slot, search-accelerator switch, bus reset, or pulse. Each request is a one-cycle strobe, with its decoded fields alongside. The bus waveforms and the serial receiver live elsewhere.

Top module: `bytecmd_parser`

## Requirements
- R1: After reset, or in the cycle after `masterRst` is sampled high, the parser is in command mode (`cmdMode`=1) and no strobe is high.
- R2: In command mode, byte E1h switches to data mode (`cmdMode`=0) and raises no strobe.
- R3: In data mode, any byte other than E3h appears on `dataByte` with `dataValid` high for one cycle, in the cycle after it is accepted.
- R4: In data mode, E3h raises no output and enters an escape-check state. If the next byte is also E3h, one literal E3h is forwarded as data and the parser stays in data mode.
- R5: In the escape-check state, a byte other than E3h is not forwarded as data. It is handled as if received in command mode, and the parser then sits in command mode, or in data mode if that byte is E1h.
- R6: A command byte 0ZZZVVV1 (bit7=0, bit0=1) raises `cfgStrobe`, with `cfgSel`=bits 6:4 and `cfgVal`=bits 3:1.
- R7: A command byte 100VSSP1 raises `bitStrobe`, with `bitVal`=bit4, `speedSel`=bits 3:2 and `armSpu`=bit1.
- R8: A command byte 101HSS01 raises `searchStrobe`, with `searchOn`=bit4 and `speedSel`=bits 3:2.
- R9: A command byte 110XSS01 raises `resetStrobe`, with `speedSel`=bits 3:2.
- R10: A command byte 111T11Q1 raises `pulseStrobe`, with `pulseProg`=bit4 and `armSpu`=bit1.
- R11: Any other command-mode byte, including E3h and any byte with bit0=0, raises no strobe and leaves the parser in command mode.
- R12: Every strobe lasts one cycle per accepted byte, at most one of `dataValid` and the five request strobes is high at once, and the fields are stable while a strobe is high.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Asynchronous active-low reset |
| masterRst | input | 1 | Synchronous return to command mode |
| byteValid | input | 1 | A received byte is present on `byteIn` |
| byteIn | input | 8 | Received byte |
| cmdMode | output | 1 | High while in command mode |
| dataValid | output | 1 | Payload byte strobe |
| dataByte | output | 8 | Payload byte |
| cfgStrobe | output | 1 | Configuration write request |
| cfgSel | output | 3 | Configuration parameter select |
| cfgVal | output | 3 | Configuration value |
| bitStrobe | output | 1 | Single-bit slot request |
| bitVal | output | 1 | Bit value for the slot |
| searchStrobe | output | 1 | Search-accelerator switch request |
| searchOn | output | 1 | Search accelerator on (1) or off (0) |
| resetStrobe | output | 1 | Bus reset request |
| pulseStrobe | output | 1 | Pulse request |
| pulseProg | output | 1 | Programming pulse (1) or strong pull-up (0) |
| speedSel | output | 2 | Speed field of bit, search and reset requests |
| armSpu | output | 1 | Strong pull-up arm flag of bit and pulse requests |

## Verification
The bench builds the parser with its default 8-bit byte width and the escape and data-mode codes at E3h and E1h. At that width all 256 byte values can be swept in each of the three states: command, data, and escape-check. That sweep covers every decode pattern, every field value, and the E1h/E3h collisions with the pulse pattern. It also covers the escaped-literal path and the fallback from the check state into command decoding.

// File: rtl/bytecmd_pkg.sv
package bytecmd_pkg;
  typedef enum logic [1:0] {
    MODE_CMD   = 2'd0,
    MODE_DATA  = 2'd1,
    MODE_CHECK = 2'd2
  } parse_mode_e;

  // strobes from control to datapath
  typedef struct packed {
    logic passData;
    logic decodeCmd;
  } parse_ctl_t;
endpackage

// File: rtl/bytecmd_ctrl.sv
module bytecmd_ctrl
  import bytecmd_pkg::*;
#(
  parameter int BYTE_W = 8,
  parameter logic [BYTE_W-1:0] ESC_CODE = 8'hE3,
  parameter logic [BYTE_W-1:0] DATA_CODE = 8'hE1
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic              masterRst,
  input  logic              byteValid,
  input  logic [BYTE_W-1:0] byteIn,
  output parse_ctl_t        ctl,
  output logic              cmdMode
);
  parse_mode_e mode, modeNext;

  always_comb begin
    modeNext = mode;
    ctl = '0;
    if (byteValid && !masterRst) begin
      unique case (mode)
        MODE_CMD: begin
          if (byteIn == DATA_CODE) modeNext = MODE_DATA;
          else ctl.decodeCmd = 1'b1;
        end
        MODE_DATA: begin
          if (byteIn == ESC_CODE) modeNext = MODE_CHECK;
          else ctl.passData = 1'b1;
        end
        MODE_CHECK: begin
          if (byteIn == ESC_CODE) begin
            ctl.passData = 1'b1;
            modeNext = MODE_DATA;
          end else if (byteIn == DATA_CODE) begin
            modeNext = MODE_DATA;
          end else begin
            ctl.decodeCmd = 1'b1;
            modeNext = MODE_CMD;
          end
        end
        default: modeNext = MODE_CMD;
      endcase
    end
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) mode <= MODE_CMD;
    else if (masterRst) mode <= MODE_CMD;
    else mode <= modeNext;
  end

  assign cmdMode = (mode == MODE_CMD);
endmodule

// File: rtl/bytecmd_dp.sv
module bytecmd_dp
  import bytecmd_pkg::*;
#(
  parameter int BYTE_W = 8
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic              masterRst,
  input  parse_ctl_t        ctl,
  input  logic [BYTE_W-1:0] byteIn,
  output logic              dataValid,
  output logic [BYTE_W-1:0] dataByte,
  output logic              cfgStrobe,
  output logic [2:0]        cfgSel,
  output logic [2:0]        cfgVal,
  output logic              bitStrobe,
  output logic              bitVal,
  output logic              searchStrobe,
  output logic              searchOn,
  output logic              resetStrobe,
  output logic              pulseStrobe,
  output logic              pulseProg,
  output logic [1:0]        speedSel,
  output logic              armSpu
);
  localparam int TOP = BYTE_W - 1;
  localparam int KIND_LO = TOP - 2;

  logic [2:0] kind;
  logic isCfg, isBit, isSearch, isReset, isPulse;

  assign kind = byteIn[TOP:KIND_LO];

  always_comb begin
    isCfg    = !byteIn[TOP] && byteIn[0];
    isBit    = (kind == 3'b100) && byteIn[0];
    isSearch = (kind == 3'b101) && (byteIn[1:0] == 2'b01);
    isReset  = (kind == 3'b110) && (byteIn[1:0] == 2'b01);
    isPulse  = (kind == 3'b111) && (byteIn[3:2] == 2'b11) && byteIn[0];
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      dataValid    <= 1'b0;
      dataByte     <= '0;
      cfgStrobe    <= 1'b0;
      bitStrobe    <= 1'b0;
      searchStrobe <= 1'b0;
      resetStrobe  <= 1'b0;
      pulseStrobe  <= 1'b0;
      cfgSel       <= '0;
      cfgVal       <= '0;
      bitVal       <= 1'b0;
      searchOn     <= 1'b0;
      pulseProg    <= 1'b0;
      speedSel     <= '0;
      armSpu       <= 1'b0;
    end else begin
      dataValid    <= ctl.passData && !masterRst;
      cfgStrobe    <= ctl.decodeCmd && isCfg;
      bitStrobe    <= ctl.decodeCmd && isBit;
      searchStrobe <= ctl.decodeCmd && isSearch;
      resetStrobe  <= ctl.decodeCmd && isReset;
      pulseStrobe  <= ctl.decodeCmd && isPulse;
      if (ctl.passData) dataByte <= byteIn;
      if (ctl.decodeCmd) begin
        cfgSel    <= byteIn[6:4];
        cfgVal    <= byteIn[3:1];
        bitVal    <= byteIn[4];
        searchOn  <= byteIn[4];
        pulseProg <= byteIn[4];
        speedSel  <= byteIn[3:2];
        armSpu    <= byteIn[1];
      end
    end
  end
endmodule

// File: rtl/bytecmd_parser.sv
module bytecmd_parser
  import bytecmd_pkg::*;
#(
  parameter int BYTE_W = 8,
  parameter logic [BYTE_W-1:0] ESC_CODE = 8'hE3,
  parameter logic [BYTE_W-1:0] DATA_CODE = 8'hE1
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic              masterRst,
  input  logic              byteValid,
  input  logic [BYTE_W-1:0] byteIn,
  output logic              cmdMode,
  output logic              dataValid,
  output logic [BYTE_W-1:0] dataByte,
  output logic              cfgStrobe,
  output logic [2:0]        cfgSel,
  output logic [2:0]        cfgVal,
  output logic              bitStrobe,
  output logic              bitVal,
  output logic              searchStrobe,
  output logic              searchOn,
  output logic              resetStrobe,
  output logic              pulseStrobe,
  output logic              pulseProg,
  output logic [1:0]        speedSel,
  output logic              armSpu
);
  parse_ctl_t ctl;

  bytecmd_ctrl #(.BYTE_W(BYTE_W), .ESC_CODE(ESC_CODE), .DATA_CODE(DATA_CODE)) u_ctrl (
    .clk(clk), .rstN(rstN), .masterRst(masterRst), .byteValid(byteValid),
    .byteIn(byteIn), .ctl(ctl), .cmdMode(cmdMode)
  );

  bytecmd_dp #(.BYTE_W(BYTE_W)) u_dp (
    .clk(clk), .rstN(rstN), .masterRst(masterRst), .ctl(ctl), .byteIn(byteIn),
    .dataValid(dataValid), .dataByte(dataByte),
    .cfgStrobe(cfgStrobe), .cfgSel(cfgSel), .cfgVal(cfgVal),
    .bitStrobe(bitStrobe), .bitVal(bitVal),
    .searchStrobe(searchStrobe), .searchOn(searchOn),
    .resetStrobe(resetStrobe), .pulseStrobe(pulseStrobe), .pulseProg(pulseProg),
    .speedSel(speedSel), .armSpu(armSpu)
  );
endmodule

// File: rtl/bytecmd_parser_chk.sv
module bytecmd_parser_chk #(
  parameter int BYTE_W = 8
) (
  input logic              clk,
  input logic              rstN,
  input logic              masterRst,
  input logic              byteValid,
  input logic [BYTE_W-1:0] byteIn,
  input logic              cmdMode,
  input logic              dataValid,
  input logic [BYTE_W-1:0] dataByte,
  input logic              cfgStrobe,
  input logic              bitStrobe,
  input logic              searchStrobe,
  input logic              resetStrobe,
  input logic              pulseStrobe
);
  // R12
  strobe_exclusive_chk: assert property (@(posedge clk) disable iff (!rstN)
    $onehot0({dataValid, cfgStrobe, bitStrobe, searchStrobe, resetStrobe, pulseStrobe}));

  // R12
  strobe_needs_byte_chk: assert property (@(posedge clk) disable iff (!rstN)
    (dataValid || cfgStrobe || bitStrobe || searchStrobe || resetStrobe || pulseStrobe)
      |-> $past(byteValid));

  // R1
  master_reset_cmd_chk: assert property (@(posedge clk) disable iff (!rstN)
    masterRst |=> cmdMode);

  // R2
  leave_cmd_on_code_chk: assert property (@(posedge clk) disable iff (!rstN)
    $fell(cmdMode) |-> ($past(byteValid) && $past(byteIn) == 8'hE1));

  // R4
  literal_escape_stays_data_chk: assert property (@(posedge clk) disable iff (!rstN)
    (dataValid && dataByte == 8'hE3) |-> !cmdMode);

  // R6
  cfg_pattern_chk: assert property (@(posedge clk) disable iff (!rstN)
    cfgStrobe |-> ($past(byteIn[0]) && !$past(byteIn[BYTE_W-1])));
endmodule

bind bytecmd_parser bytecmd_parser_chk #(.BYTE_W(BYTE_W)) u_chk (
  .clk(clk), .rstN(rstN), .masterRst(masterRst), .byteValid(byteValid),
  .byteIn(byteIn), .cmdMode(cmdMode), .dataValid(dataValid), .dataByte(dataByte),
  .cfgStrobe(cfgStrobe), .bitStrobe(bitStrobe), .searchStrobe(searchStrobe),
  .resetStrobe(resetStrobe), .pulseStrobe(pulseStrobe)
);

// File: tb/bytecmd_parser_test.sv
module bytecmd_parser_test;
  logic clk = 1'b0;
  logic rstN = 1'b0;
  logic masterRst = 1'b0;
  logic byteValid = 1'b0;
  logic [7:0] byteIn = '0;
  logic cmdMode, dataValid, cfgStrobe, bitStrobe, bitVal, searchStrobe, searchOn;
  logic resetStrobe, pulseStrobe, pulseProg, armSpu;
  logic [7:0] dataByte;
  logic [2:0] cfgSel, cfgVal;
  logic [1:0] speedSel;
  int errors = 0;
  int checks = 0;
  bit finished = 0;

  always #10 clk = ~clk;

  bytecmd_parser uut (
    .clk(clk), .rstN(rstN), .masterRst(masterRst), .byteValid(byteValid),
    .byteIn(byteIn), .cmdMode(cmdMode), .dataValid(dataValid), .dataByte(dataByte),
    .cfgStrobe(cfgStrobe), .cfgSel(cfgSel), .cfgVal(cfgVal),
    .bitStrobe(bitStrobe), .bitVal(bitVal),
    .searchStrobe(searchStrobe), .searchOn(searchOn),
    .resetStrobe(resetStrobe), .pulseStrobe(pulseStrobe), .pulseProg(pulseProg),
    .speedSel(speedSel), .armSpu(armSpu)
  );

  task automatic chk(input bit ok, input string tag, input int act, input int exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
    end
  endtask

  task automatic sendByte(input logic [7:0] b);
    @(negedge clk);
    byteIn = b;
    byteValid = 1'b1;
    @(negedge clk);
    byteValid = 1'b0;
  endtask

  // expected outcome of a byte decoded in command mode
  task automatic checkCmd(input logic [7:0] b, input string ctx);
    bit eCfg, eBit, eSrch, eRst, ePulse;
    eCfg   = !b[7] && b[0];
    eBit   = (b[7:5] == 3'b100) && b[0];
    eSrch  = (b[7:5] == 3'b101) && (b[1:0] == 2'b01);
    eRst   = (b[7:5] == 3'b110) && (b[1:0] == 2'b01);
    ePulse = (b[7:5] == 3'b111) && (b[3:2] == 2'b11) && b[0];
    chk(dataValid == 1'b0, {ctx, " R11 no data"}, dataValid, 0);
    chk(cfgStrobe == eCfg, {ctx, " R6 cfgStrobe"}, cfgStrobe, eCfg);
    chk(bitStrobe == eBit, {ctx, " R7 bitStrobe"}, bitStrobe, eBit);
    chk(searchStrobe == eSrch, {ctx, " R8 searchStrobe"}, searchStrobe, eSrch);
    chk(resetStrobe == eRst, {ctx, " R9 resetStrobe"}, resetStrobe, eRst);
    chk(pulseStrobe == ePulse, {ctx, " R10 pulseStrobe"}, pulseStrobe, ePulse);
    chk(cmdMode == (b != 8'hE1), {ctx, " R2 R11 mode"}, cmdMode, b != 8'hE1);
    if (eCfg) begin
      chk(cfgSel == b[6:4], {ctx, " R6 cfgSel"}, cfgSel, b[6:4]);
      chk(cfgVal == b[3:1], {ctx, " R6 cfgVal"}, cfgVal, b[3:1]);
    end
    if (eBit) begin
      chk(bitVal == b[4], {ctx, " R7 bitVal"}, bitVal, b[4]);
      chk(speedSel == b[3:2], {ctx, " R7 speed"}, speedSel, b[3:2]);
      chk(armSpu == b[1], {ctx, " R7 arm"}, armSpu, b[1]);
    end
    if (eSrch) begin
      chk(searchOn == b[4], {ctx, " R8 on"}, searchOn, b[4]);
      chk(speedSel == b[3:2], {ctx, " R8 speed"}, speedSel, b[3:2]);
    end
    if (eRst) chk(speedSel == b[3:2], {ctx, " R9 speed"}, speedSel, b[3:2]);
    if (ePulse) begin
      chk(pulseProg == b[4], {ctx, " R10 prog"}, pulseProg, b[4]);
      chk(armSpu == b[1], {ctx, " R10 arm"}, armSpu, b[1]);
    end
    // R12 one cycle later everything is quiet
    @(negedge clk);
    chk({dataValid, cfgStrobe, bitStrobe, searchStrobe, resetStrobe, pulseStrobe} == 6'b0,
        {ctx, " R12 single cycle"},
        {dataValid, cfgStrobe, bitStrobe, searchStrobe, resetStrobe, pulseStrobe}, 0);
  endtask

  initial begin
    repeat (3) @(negedge clk);
    rstN = 1'b1;
    @(negedge clk);
    // R1 reset state
    chk(cmdMode == 1'b1, "R1 reset mode", cmdMode, 1);
    chk({dataValid, cfgStrobe, bitStrobe, searchStrobe, resetStrobe, pulseStrobe} == 6'b0,
        "R1 reset strobes",
        {dataValid, cfgStrobe, bitStrobe, searchStrobe, resetStrobe, pulseStrobe}, 0);

    // command mode sweep
    for (int b = 0; b < 256; b++) begin
      sendByte(8'(b));
      checkCmd(8'(b), "cmd");
      if (b == 8'hE1) begin
        sendByte(8'hE3);
        sendByte(8'h00);
        chk(cmdMode == 1'b1, "R5 back to cmd", cmdMode, 1);
      end
    end

    // data mode sweep
    sendByte(8'hE1);
    chk(cmdMode == 1'b0, "R2 to data", cmdMode, 0);
    for (int b = 0; b < 256; b++) begin
      if (b != 8'hE3) begin
        sendByte(8'(b));
        chk(dataValid == 1'b1, "R3 valid", dataValid, 1);
        chk(dataByte == 8'(b), "R3 byte", dataByte, b);
        chk(cmdMode == 1'b0, "R3 mode", cmdMode, 0);
      end else begin
        sendByte(8'hE3);
        chk(dataValid == 1'b0, "R4 escape silent", dataValid, 0);
        chk(cmdMode == 1'b0, "R4 escape mode", cmdMode, 0);
        sendByte(8'hE3);
        chk(dataValid == 1'b1, "R4 literal valid", dataValid, 1);
        chk(dataByte == 8'hE3, "R4 literal byte", dataByte, 8'hE3);
        chk(cmdMode == 1'b0, "R4 stays data", cmdMode, 0);
      end
    end

    // escape-check sweep
    for (int b = 0; b < 256; b++) begin
      if (b != 8'hE3) begin
        sendByte(8'hE3);
        sendByte(8'(b));
        checkCmd(8'(b), "R5 check");
        if (b != 8'hE1) sendByte(8'hE1);
      end
    end

    // R1 master reset from data mode
    @(negedge clk);
    masterRst = 1'b1;
    @(negedge clk);
    masterRst = 1'b0;
    chk(cmdMode == 1'b1, "R1 master reset mode", cmdMode, 1);
    sendByte(8'h41);
    chk(cfgStrobe == 1'b1, "R1 decode after master reset", cfgStrobe, 1);
    chk(dataValid == 1'b0, "R1 no data after master reset", dataValid, 0);

    finished = 1;
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end

  initial begin
    repeat (150000) @(posedge clk);
    if (!finished) begin
      errors++;
      checks++;
      $display("FAIL watchdog actual=1 expected=0");
      $display("Result: errors=%0d of %0d checks", errors, checks);
      $finish;
    end
  end
endmodule